// File: doc/BRIEF.md
# Multilane Double-Data-Rate Sample Deserializer

This block turns several serial converter lanes into parallel samples. Each lane carries one bit on the falling edge and one bit on the rising edge of a fast bit clock. A capture stage on each lane joins the two bits of a bit-clock period into a pair. A per-lane shift register then gathers six pairs into one 12-bit sample.

A slow system clock runs at one sixth of the bit-clock rate, and its rising edges coincide with bit-clock rising edges. On each system-clock edge the block moves the complete multi-lane frame into an output register. A separate flag marks the words that hold real data.

The lock signal of the clock generator acts as an active-low asynchronous reset for both clock domains. The user must generate the clocks and align their phases, and must deliver the serial data so that frame boundaries match the system-clock edges.

Top module: `ddr_lane_deser`

## Requirements
- R1: While `lock_n` is low, `word_out` is all zeros and `word_valid` is low. This clearing takes effect without waiting for a clock edge.
- R2: On the first two `sys_clk` rising edges after `lock_n` rises, `word_valid` stays low and `word_out` stays zero. From the third such edge on, `word_valid` is high.
- R3: Within each bit pair, the bit taken on the falling edge lands one position above the bit taken on the following rising edge. The earliest bit of a frame therefore appears at bit 11 of its lane's sample, and the latest at bit 0.
- R4: The sample of lane k occupies `word_out[12k+11:12k]`, with lane 0 in the least significant slice. Lanes do not affect one another.
- R5: Count bit-clock rising edges back from a `sys_clk` rising edge. The pairs whose rising-edge bits are sampled seven, six, five, four, three and two edges before it form the word registered on that edge, with the pair sampled seven edges before as the most significant pair.
- R6: Once `word_valid` is high, it stays high on every `sys_clk` cycle until `lock_n` falls. Every such cycle presents the newly completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast bit clock; data is sampled on both of its edges |
| sys_clk | input | 1 | Frame-rate clock at one sixth of `bit_clk`, rising edges aligned to it |
| lock_n | input | 1 | Clock-lock indication, low holds every register cleared |
| lanes_in | input | 8 | One serial data bit per lane |
| word_out | output | 96 | Parallel frame, 12 bits per lane |
| word_valid | output | 1 | High while `word_out` holds a completed frame |

## Verification
The bench builds the block with its default 8 lanes of 12 bits and with the falling-edge bit placed first. The 96-bit word therefore has six pairs per lane and two suppressed warm-up words, so every lane slice, every pair position and the whole warm-up window can be observed directly. Lock is released at two different bit-clock phases within a frame, which shows that the warm-up suppression covers partially filled shift registers. The patterns include walking ones, a lone MSB or second bit per lane, alternating values, all ones and random frames, which together expose swapped pair order, lane misplacement and an off-by-one-pair frame alignment.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
   localparam int unsigned DFLT_LANES      = 8;
   localparam int unsigned DFLT_FRAME_BITS = 12;
   localparam int unsigned DFLT_WARM       = 2;

   function automatic int unsigned cnt_width(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture #(
   parameter bit FALL_FIRST = 1'b1
) (
   input  logic       bit_clk,
   input  logic       lock_n,
   input  logic       din,
   output logic [1:0] pair
);
   logic fall_q;

   always_ff @(negedge bit_clk or negedge lock_n) begin
      if (!lock_n) fall_q <= 1'b0;
      else         fall_q <= din;
   end

   generate
      if (FALL_FIRST) begin : g_fall_high
         always_ff @(posedge bit_clk or negedge lock_n) begin
            if (!lock_n) pair <= 2'b00;
            else         pair <= {fall_q, din};
         end
      end else begin : g_rise_high
         always_ff @(posedge bit_clk or negedge lock_n) begin
            if (!lock_n) pair <= 2'b00;
            else         pair <= {din, fall_q};
         end
      end
   endgenerate
endmodule

// File: rtl/ddr_lane_shift.sv
module ddr_lane_shift #(
   parameter int unsigned FRAME_BITS = 12
) (
   input  logic                  bit_clk,
   input  logic                  lock_n,
   input  logic [1:0]            pair,
   output logic [FRAME_BITS-1:0] acc
);
   always_ff @(posedge bit_clk or negedge lock_n) begin
      if (!lock_n) acc <= '0;
      else         acc <= {acc[FRAME_BITS-3:0], pair};
   end
endmodule

// File: rtl/ddr_frame_handoff.sv
module ddr_frame_handoff
   import ddr_deser_pkg::*;
#(
   parameter int unsigned WIDTH = 96,
   parameter int unsigned WARM  = 2
) (
   input  logic             sys_clk,
   input  logic             lock_n,
   input  logic [WIDTH-1:0] frame_in,
   output logic [WIDTH-1:0] word,
   output logic             valid
);
   localparam int unsigned CW = cnt_width(WARM);

   logic [CW-1:0] warm_cnt;
   logic          warm_done;

   assign warm_done = (warm_cnt == CW'(WARM));

   always_ff @(posedge sys_clk or negedge lock_n) begin
      if (!lock_n) begin
         warm_cnt <= '0;
         valid    <= 1'b0;
         word     <= '0;
      end else begin
         if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
         valid <= warm_done;
         if (warm_done) word <= frame_in;
      end
   end
endmodule

// File: rtl/ddr_lane_deser.sv
module ddr_lane_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned LANES       = DFLT_LANES,
   parameter int unsigned FRAME_BITS  = DFLT_FRAME_BITS,
   parameter int unsigned WARM_FRAMES = DFLT_WARM,
   parameter bit          FALL_FIRST  = 1'b1
) (
   input  logic                        bit_clk,
   input  logic                        sys_clk,
   input  logic                        lock_n,
   input  logic [LANES-1:0]            lanes_in,
   output logic [LANES*FRAME_BITS-1:0] word_out,
   output logic                        word_valid
);
   localparam int unsigned WIDTH = LANES * FRAME_BITS;

   generate
      if ((FRAME_BITS % 2) != 0 || FRAME_BITS < 4) begin : g_bad_frame
         $error("FRAME_BITS must be even and at least 4");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (WARM_FRAMES < 1) begin : g_bad_warm
         $error("WARM_FRAMES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] frame_flat;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [1:0]            pair_k;
      logic [FRAME_BITS-1:0] acc_k;

      ddr_pair_capture #(.FALL_FIRST(FALL_FIRST)) i_cap (
         .bit_clk (bit_clk),
         .lock_n  (lock_n),
         .din     (lanes_in[k]),
         .pair    (pair_k)
      );

      ddr_lane_shift #(.FRAME_BITS(FRAME_BITS)) i_shift (
         .bit_clk (bit_clk),
         .lock_n  (lock_n),
         .pair    (pair_k),
         .acc     (acc_k)
      );

      assign frame_flat[k*FRAME_BITS +: FRAME_BITS] = acc_k;
   end

   ddr_frame_handoff #(.WIDTH(WIDTH), .WARM(WARM_FRAMES)) i_handoff (
      .sys_clk  (sys_clk),
      .lock_n   (lock_n),
      .frame_in (frame_flat),
      .word     (word_out),
      .valid    (word_valid)
   );
endmodule

// File: rtl/ddr_lane_deser_chk.sv
module ddr_lane_deser_chk
   import ddr_deser_pkg::*;
#(
   parameter int unsigned WIDTH = 96,
   parameter int unsigned WARM  = 2
) (
   input logic             bit_clk,
   input logic             sys_clk,
   input logic             lock_n,
   input logic [WIDTH-1:0] word_out,
   input logic             word_valid
);
   localparam int unsigned CW = cnt_width(WARM + 1);

   logic [CW-1:0] seen;

   always_ff @(posedge sys_clk or negedge lock_n) begin
      if (!lock_n)                 seen <= '0;
      else if (seen != CW'(WARM + 1)) seen <= seen + 1'b1;
   end

   assert_clear_in_reset_R1: assert property (@(posedge bit_clk)
      !lock_n |-> (word_out == '0 && !word_valid))
      else $error("R1: outputs not cleared while lock is low");

   assert_warmup_quiet_R2: assert property (@(posedge sys_clk) disable iff (!lock_n)
      (seen <= CW'(WARM)) |-> !word_valid)
      else $error("R2: valid during warm-up");

   assert_zero_until_valid_R2: assert property (@(posedge sys_clk) disable iff (!lock_n)
      !word_valid |-> (word_out == '0))
      else $error("R2: nonzero word while not valid");

   assert_valid_after_warm_R6: assert property (@(posedge sys_clk) disable iff (!lock_n)
      (seen == CW'(WARM + 1)) |-> word_valid)
      else $error("R6: valid missing after warm-up");

   assert_valid_sticks_R6: assert property (@(posedge sys_clk) disable iff (!lock_n)
      word_valid |=> word_valid)
      else $error("R6: valid dropped while locked");
endmodule

bind ddr_lane_deser ddr_lane_deser_chk #(
   .WIDTH (LANES * FRAME_BITS),
   .WARM  (WARM_FRAMES)
) i_chk (
   .bit_clk    (bit_clk),
   .sys_clk    (sys_clk),
   .lock_n     (lock_n),
   .word_out   (word_out),
   .word_valid (word_valid)
);

// File: tb/test_ddr_lane_deser.sv
`timescale 1ns/1ps
module test_ddr_lane_deser;
   localparam int LANES = 8;
   localparam int FB    = 12;
   localparam int W     = LANES * FB;

   logic           bit_clk = 1'b0;
   logic           sys_clk = 1'b0;
   logic           lock_n  = 1'b1;
   logic [LANES-1:0] lanes_in = '0;
   logic [W-1:0]   word_out;
   logic           word_valid;

   int checks = 0;
   int errors = 0;
   int phase  = 0;
   int sedge  = 0;
   int mode   = 0;
   int fcnt   = 0;
   bit done   = 1'b0;

   logic [FB-1:0] cur [LANES];
   logic [W-1:0]  exp_word [8];
   int            exp_mode [8];

   ddr_lane_deser i_ddr_lane_deser (
      .bit_clk    (bit_clk),
      .sys_clk    (sys_clk),
      .lock_n     (lock_n),
      .lanes_in   (lanes_in),
      .word_out   (word_out),
      .word_valid (word_valid)
   );

   // 125 MHz bit clock; system clock rises with every sixth bit-clock rise
   initial begin
      #3;
      forever begin
         for (int p = 0; p < 6; p++) begin
            phase = p;
            if (p == 0) sedge = sedge + 1;
            bit_clk = 1'b1;
            if (p == 0) sys_clk = 1'b1;
            if (p == 3) sys_clk = 1'b0;
            #4 bit_clk = 1'b0;
            #4;
         end
      end
   end

   function automatic logic [FB-1:0] gen_sample(int md, int lane, int fr);
      case (md)
         0: return FB'($urandom);
         1: return '1;
         2: return lane[0] ? 12'h555 : 12'hAAA;
         3: return 12'h001 << ((lane + fr) % FB);
         4: return lane[0] ? 12'h400 : 12'h800;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(int md);
      if (md == 4) return "R3";
      if (md == 3 || md == 2) return "R4";
      return "R5";
   endfunction

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
      end
   endtask

   // Serial driver: pair 0 of a frame starts at phase 4 (R5 alignment)
   initial begin
      void'($urandom(32'h5EED));
      for (int k = 0; k < LANES; k++) cur[k] = '0;
      for (int s = 0; s < 8; s++) begin exp_word[s] = '0; exp_mode[s] = 5; end
      forever begin
         int p, j;
         logic [W-1:0] wv;
         @(posedge bit_clk);
         p = phase;
         if (p == 4) begin
            wv = '0;
            for (int k = 0; k < LANES; k++) begin
               cur[k] = gen_sample(mode, k, fcnt);
               wv[k*FB +: FB] = cur[k];
            end
            exp_word[(sedge + 2) % 8] = wv;
            exp_mode[(sedge + 2) % 8] = mode;
            fcnt++;
         end
         j = (p + 2) % 6;
         #2;
         for (int k = 0; k < LANES; k++) lanes_in[k] = cur[k][FB-1-2*j];
         @(negedge bit_clk);
         #2;
         for (int k = 0; k < LANES; k++) lanes_in[k] = cur[k][FB-2-2*j];
      end
   end

   // Output monitor, sampled 2 ns after each system-clock rise
   initial begin
      int since = 0;
      forever begin
         @(posedge sys_clk);
         #2;
         if (!lock_n) begin
            since = 0;
            check("R1", {word_valid, word_out}, '0);
         end else begin
            since++;
            if (since <= 2) begin
               check("R2", {word_valid, word_out}, '0);
            end else begin
               check("R6", {{(W){1'b0}}, word_valid}, {{(W){1'b0}}, 1'b1});
               check(tag_of(exp_mode[sedge % 8]), word_out, exp_word[sedge % 8]);
            end
         end
      end
   end

   task automatic release_lock(int skew);
      @(posedge sys_clk);
      repeat (skew) @(posedge bit_clk);
      #3 lock_n = 1'b1;
   endtask

   task automatic run_frames(int md, int n);
      mode = md;
      repeat (n) @(posedge sys_clk);
   endtask

   initial begin
      #1 lock_n = 1'b0;
      #1;
      check("R1", {word_valid, word_out}, '0);
      repeat (3) @(posedge sys_clk);
      release_lock(2);
      run_frames(3, 14);
      run_frames(4, 6);
      run_frames(2, 6);
      run_frames(1, 6);
      run_frames(5, 4);
      // mid-run loss of lock, then re-lock at a different phase
      @(posedge bit_clk);
      #3 lock_n = 1'b0;
      #1;
      check("R1", {word_valid, word_out}, '0);
      repeat (3) @(posedge sys_clk);
      release_lock(5);
      run_frames(0, 40);
      run_frames(3, 8);
      #5;
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule